// File: doc/BRIEF.md
# Four-Channel Tone Generator with Option Byte

This block produces four 1-bit audio waveforms. Every channel holds an 8-bit reload value and a down-counter. Each time the counter steps past zero it reloads and raises an underflow. On that underflow the channel output either inverts, giving a square wave, or copies one bit of a shared pseudo-random shift register, giving noise. A live per-channel select input chooses between square and noise.

A single 8-bit option byte sets how the channels are clocked and combined. Its lowest bit picks the base tick rate that all channels use by default. Two bits let channel 0 and channel 2 count on every master clock instead of on the base tick. Two further bits fuse a channel pair into a single 16-bit counter. Two more bits add a sampling high-pass stage to channel 0 and channel 2. The top bit picks the length of the noise shift register.

Any write to the option byte or to a reload value restarts the whole block from a known state. This lets a host, or a bench, predict every output edge from the cycle of the last write.

Top module: `tone_quad`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all four outputs are 0.
- R2: A write to the option byte or to any reload value clears the prescaler, all counters, the noise registers, the output flops and the filter flops, so all outputs read 0 in the cycle after the write edge.
- R3: The base tick comes from a free-running prescaler. It fires once every 28 master clocks when option bit 0 is 0, and once every 114 master clocks when option bit 0 is 1. The first tick after a write comes 28 (or 114) clocks after the write edge. Channels 1 and 3 always count on the base tick.
- R4: Option bit 6 makes channel 0 count on every master clock, and option bit 5 does the same for channel 2. When the bit is clear, the channel counts on the base tick.
- R5: A counter cleared to zero underflows on its first enabled step and loads its reload value N. After that it underflows every N+1 enabled steps. In square mode the output inverts on every underflow.
- R6: Option bit 4 fuses channels 0 and 1 into one 16-bit counter, with channel 1's value as the high byte and channel 0's as the low byte. The fused counter steps at channel 0's rate and drives output 1, while output 0 stays 0.
- R7: Option bit 3 fuses channels 2 and 3 in the same way, with channel 3's value as the high byte. The fused counter steps at channel 2's rate and drives output 3, while output 2 stays 0.
- R8: With option bit 2 set, output 0 equals channel 0's waveform XOR a flop that captures that waveform on each underflow of channel 1.
- R9: With option bit 1 set, output 2 equals channel 2's waveform XOR a flop that captures that waveform on each underflow of channel 3.
- R10: In noise mode an underflow loads the output with the top bit of a shift register that steps on every master clock and is cleared to 0 by a write. With option bit 7 = 0 the register is 17 bits long and steps as s <= {s[15:0], ~(s[16]^s[13])}, output s[16]. With bit 7 = 1 it is 9 bits long and steps as s <= {s[7:0], ~(s[8]^s[4])}, output s[8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opt_we | input | 1 | Write strobe for the option byte |
| opt_wdata | input | 8 | Option byte value |
| div_we | input | NCH | One-hot write strobes for the channel reload values |
| div_wdata | input | DIV_W | Reload value to write |
| noise_sel | input | NCH | Per channel: 1 selects noise, 0 selects square |
| wave_out | output | NCH | Channel waveforms |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit reload values, prescaler limits of 28 and 114, and 17-bit and 9-bit noise registers. The fast-clock bits make per-cycle counter behaviour visible within a handful of cycles. A fused pair set to 0x0102 reaches its 16-bit underflow boundary in 259 cycles. The 114-clock slow tick shows several edges within about 500 cycles. The filter tests mix a fast channel with a base-tick sampler, so the XOR term takes both values.

// File: rtl/tq_pkg.sv
package tq_pkg;

    // Option byte layout; the bit order is fixed by how the channels decode it.
    typedef struct packed {
        logic poly_short;  // bit 7: short noise register
        logic fast_a;      // bit 6: channel 0 on master clock
        logic fast_b;      // bit 5: channel 2 on master clock
        logic join_a;      // bit 4: fuse channels 0/1
        logic join_b;      // bit 3: fuse channels 2/3
        logic hp_a;        // bit 2: filter on channel 0
        logic hp_b;        // bit 1: filter on channel 2
        logic tick_slow;   // bit 0: slow base tick
    } opt_t;

endpackage

// File: rtl/tq_prescaler.sv
module tq_prescaler #(
    parameter int FAST_DIV = 28,
    parameter int SLOW_DIV = 114
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic slow,
    output logic tick
);
    localparam int CW = $clog2(SLOW_DIV);
    localparam logic [CW-1:0] TOP_F = CW'(FAST_DIV - 1);
    localparam logic [CW-1:0] TOP_S = CW'(SLOW_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    assign tick = (st_q.cnt == (slow ? TOP_S : TOP_F));

    always_comb begin
        st_d = st_q;
        if (clr || tick) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tq_poly.sv
module tq_poly #(
    parameter int LONG_LEN  = 17,
    parameter int LONG_TAP  = 14,
    parameter int SHORT_LEN = 9,
    parameter int SHORT_TAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic short_sel,
    output logic noise_bit
);
    typedef struct packed {
        logic [LONG_LEN-1:0]  lg;
        logic [SHORT_LEN-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    assign noise_bit = short_sel ? st_q.sh[SHORT_LEN-1] : st_q.lg[LONG_LEN-1];

    // XNOR feedback keeps the all-zero clear state from locking up.
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.lg = {st_q.lg[LONG_LEN-2:0],
                       ~(st_q.lg[LONG_LEN-1] ^ st_q.lg[LONG_TAP-1])};
            st_d.sh = {st_q.sh[SHORT_LEN-2:0],
                       ~(st_q.sh[SHORT_LEN-1] ^ st_q.sh[SHORT_TAP-1])};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tq_pair.sv
module tq_pair #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en_lo,
    input  logic          en_hi,
    input  logic          joined,
    input  logic          hp_on,
    input  logic          noise_lo,
    input  logic          noise_hi,
    input  logic          noise_bit,
    input  logic [DW-1:0] rld_lo,
    input  logic [DW-1:0] rld_hi,
    output logic          wave_lo,
    output logic          wave_hi
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic          tone_lo;
        logic          tone_hi;
        logic          hold;
    } st_t;

    st_t st_d, st_q;
    logic uf_lo, uf_hi;

    always_comb begin
        st_d  = st_q;
        uf_lo = 1'b0;
        uf_hi = 1'b0;
        if (clr) begin
            st_d = '0;
        end else begin
            if (joined) begin
                if (en_lo) begin
                    if ({st_q.hi, st_q.lo} == '0) begin
                        {st_d.hi, st_d.lo} = {rld_hi, rld_lo};
                        uf_hi = 1'b1;
                    end else begin
                        {st_d.hi, st_d.lo} = {st_q.hi, st_q.lo} - PW'(1);
                    end
                end
            end else begin
                if (en_lo) begin
                    if (st_q.lo == '0) begin
                        st_d.lo = rld_lo;
                        uf_lo   = 1'b1;
                    end else begin
                        st_d.lo = st_q.lo - DW'(1);
                    end
                end
                if (en_hi) begin
                    if (st_q.hi == '0) begin
                        st_d.hi = rld_hi;
                        uf_hi   = 1'b1;
                    end else begin
                        st_d.hi = st_q.hi - DW'(1);
                    end
                end
            end
            if (uf_lo) st_d.tone_lo = noise_lo ? noise_bit : ~st_q.tone_lo;
            if (uf_hi) begin
                st_d.tone_hi = noise_hi ? noise_bit : ~st_q.tone_hi;
                st_d.hold    = st_q.tone_lo;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave_lo = joined ? 1'b0 : (hp_on ? (st_q.tone_lo ^ st_q.hold) : st_q.tone_lo);
    assign wave_hi = st_q.tone_hi;
endmodule

// File: rtl/tone_quad.sv
module tone_quad
    import tq_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int DIV_W     = 8,
    parameter int FAST_DIV  = 28,
    parameter int SLOW_DIV  = 114,
    parameter int LONG_LEN  = 17,
    parameter int LONG_TAP  = 14,
    parameter int SHORT_LEN = 9,
    parameter int SHORT_TAP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opt_we,
    input  logic [7:0]       opt_wdata,
    input  logic [NCH-1:0]   div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic [NCH-1:0]   noise_sel,
    output logic [NCH-1:0]   wave_out
);
    localparam int NPAIR = NCH / 2;

    typedef struct packed {
        opt_t                       opt;
        logic [NCH-1:0][DIV_W-1:0]  div;
    } st_t;

    st_t st_d, st_q;
    logic       wr_any;
    logic       tick;
    logic       noise_bit;
    logic [7:0] opt_bits;
    logic [1:0] fast_v, join_v, hp_v;

    assign wr_any   = opt_we | (|div_we);
    assign opt_bits = st_q.opt;
    assign fast_v   = {st_q.opt.fast_b, st_q.opt.fast_a};
    assign join_v   = {st_q.opt.join_b, st_q.opt.join_a};
    assign hp_v     = {st_q.opt.hp_b,   st_q.opt.hp_a};

    always_comb begin
        st_d = st_q;
        if (opt_we) st_d.opt = opt_t'(opt_wdata);
        for (int i = 0; i < NCH; i++) begin
            if (div_we[i]) st_d.div[i] = div_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tq_prescaler #(
        .FAST_DIV(FAST_DIV),
        .SLOW_DIV(SLOW_DIV)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (wr_any),
        .slow (st_q.opt.tick_slow),
        .tick (tick)
    );

    tq_poly #(
        .LONG_LEN (LONG_LEN),
        .LONG_TAP (LONG_TAP),
        .SHORT_LEN(SHORT_LEN),
        .SHORT_TAP(SHORT_TAP)
    ) u_poly (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wr_any),
        .short_sel(st_q.opt.poly_short),
        .noise_bit(noise_bit)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        tq_pair #(
            .DW(DIV_W)
        ) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (wr_any),
            .en_lo    (fast_v[g] | tick),
            .en_hi    (tick),
            .joined   (join_v[g]),
            .hp_on    (hp_v[g]),
            .noise_lo (noise_sel[2*g]),
            .noise_hi (noise_sel[2*g+1]),
            .noise_bit(noise_bit),
            .rld_lo   (st_q.div[2*g]),
            .rld_hi   (st_q.div[2*g+1]),
            .wave_lo  (wave_out[2*g]),
            .wave_hi  (wave_out[2*g+1])
        );
    end
endmodule

// File: rtl/tq_checker.sv
module tq_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr,
    input logic           tick,
    input logic [7:0]     opt,
    input logic [NCH-1:0] wave_out
);
    // R2: every write restarts the outputs at 0
    p_write_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (wave_out == '0));

    // R3: the prescaler never ticks twice in a row
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3: channel 1 moves only after a base tick
    p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(wr) && !$past(opt[4])) |-> $stable(wave_out[1]));

    // R4: channel 0 on the base tick, unfiltered, moves only after a tick
    p_slow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(wr) && !$past(opt[6]) && !$past(opt[2]))
        |-> $stable(wave_out[0]));

    // R6: fused low channel is silent
    p_join_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        opt[4] |-> !wave_out[0]);

    // R7: fused low channel is silent
    p_join_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        opt[3] |-> !wave_out[2]);
endmodule

bind tone_quad tq_checker #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_any),
    .tick    (tick),
    .opt     (opt_bits),
    .wave_out(wave_out)
);

// File: tb/sim_tone_quad.sv
module sim_tone_quad;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_we = 1'b0;
    logic [7:0] opt_wdata = '0;
    logic [3:0] div_we = '0;
    logic [7:0] div_wdata = '0;
    logic [3:0] noise_sel = '0;
    logic [3:0] wave_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    tone_quad u0 (
        .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata),
        .div_we(div_we), .div_wdata(div_wdata), .noise_sel(noise_sel),
        .wave_out(wave_out)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Square output after edge k: first inversion at edge f, then every p edges.
    function automatic int sq(input int k, input int f, input int p);
        if (k < f) return 0;
        return ((k - f) / p + 1) % 2;
    endfunction

    task automatic wr_div(input int ch, input int v);
        @(negedge clk);
        div_we = 4'(1 << ch);
        div_wdata = 8'(v);
        @(posedge clk);
        @(negedge clk);
        div_we = '0;
    endtask

    // Leaves the caller at the falling edge after the write edge (k = 0).
    task automatic wr_opt(input int v);
        @(negedge clk);
        opt_we = 1'b1;
        opt_wdata = 8'(v);
        @(posedge clk);
        @(negedge clk);
        opt_we = 1'b0;
        check_eq("R2 outputs cleared by write", int'(wave_out), 0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 outputs in reset", int'(wave_out), 0);
        rst_n = 1'b1;
        step();
        check_eq("R1 outputs after reset", int'(wave_out), 0);
    endtask

    task automatic t_fast();
        noise_sel = '0;
        wr_div(0, 3); wr_div(1, 0); wr_div(2, 1); wr_div(3, 0);
        wr_opt(8'h60);
        for (int k = 1; k <= 60; k++) begin
            step();
            check_eq("R5 ch0 fast period", int'(wave_out[0]), sq(k, 1, 4));
            check_eq("R4 ch2 fast period", int'(wave_out[2]), sq(k, 1, 2));
            check_eq("R3 ch1 base tick", int'(wave_out[1]), sq(k, 28, 28));
            check_eq("R3 ch3 base tick", int'(wave_out[3]), sq(k, 28, 28));
        end
        // a reload write mid-run restarts everything
        @(negedge clk);
        div_we = 4'b0001; div_wdata = 8'd3;
        @(posedge clk);
        @(negedge clk);
        div_we = '0;
        check_eq("R2 mid-run write clears", int'(wave_out), 0);
        for (int k = 1; k <= 12; k++) begin
            step();
            check_eq("R2 restart from zero", int'(wave_out[0]), sq(k, 1, 4));
        end
    endtask

    task automatic t_base();
        wr_div(0, 0); wr_div(1, 1); wr_div(2, 0); wr_div(3, 2);
        wr_opt(8'h00);
        for (int k = 1; k <= 300; k++) begin
            step();
            check_eq("R3 ch0 fast tick", int'(wave_out[0]), sq(k, 28, 28));
            check_eq("R3 ch1 fast tick", int'(wave_out[1]), sq(k, 28, 56));
            check_eq("R4 ch2 on tick", int'(wave_out[2]), sq(k, 28, 28));
            check_eq("R3 ch3 fast tick", int'(wave_out[3]), sq(k, 28, 84));
        end
        wr_opt(8'h01);
        for (int k = 1; k <= 500; k++) begin
            step();
            check_eq("R3 ch0 slow tick", int'(wave_out[0]), sq(k, 114, 114));
            check_eq("R3 ch1 slow tick", int'(wave_out[1]), sq(k, 114, 228));
        end
    endtask

    task automatic t_join_a();
        wr_div(0, 8'h02); wr_div(1, 8'h01);
        wr_opt(8'h50);
        for (int k = 1; k <= 600; k++) begin
            step();
            check_eq("R6 fused low silent", int'(wave_out[0]), 0);
            check_eq("R6 fused 16-bit period", int'(wave_out[1]), sq(k, 1, 259));
        end
    endtask

    task automatic t_join_b();
        wr_div(2, 8'h05); wr_div(3, 8'h00);
        wr_opt(8'h28);
        for (int k = 1; k <= 40; k++) begin
            step();
            check_eq("R7 fused low silent", int'(wave_out[2]), 0);
            check_eq("R7 fused 16-bit period", int'(wave_out[3]), sq(k, 1, 6));
        end
    endtask

    task automatic t_filter();
        wr_div(0, 2); wr_div(1, 0); wr_div(2, 4); wr_div(3, 0);
        wr_opt(8'h66);
        for (int k = 1; k <= 200; k++) begin
            int m, h0, h2;
            step();
            m  = (k / 28) * 28;
            h0 = (m >= 28) ? sq(m - 1, 1, 3) : 0;
            h2 = (m >= 28) ? sq(m - 1, 1, 5) : 0;
            check_eq("R8 filtered ch0", int'(wave_out[0]), sq(k, 1, 3) ^ h0);
            check_eq("R9 filtered ch2", int'(wave_out[2]), sq(k, 1, 5) ^ h2);
            check_eq("R8 sampler ch1", int'(wave_out[1]), sq(k, 28, 28));
            check_eq("R9 sampler ch3", int'(wave_out[3]), sq(k, 28, 28));
        end
    endtask

    task automatic t_noise();
        logic [16:0] s17;
        logic [8:0]  s9;
        wr_div(0, 0);
        noise_sel = 4'b0001;
        wr_opt(8'h40);
        s17 = '0;
        for (int k = 1; k <= 80; k++) begin
            step();
            check_eq("R10 long noise", int'(wave_out[0]), int'(s17[16]));
            s17 = {s17[15:0], ~(s17[16] ^ s17[13])};
        end
        wr_opt(8'hC0);
        s9 = '0;
        for (int k = 1; k <= 60; k++) begin
            step();
            check_eq("R10 short noise", int'(wave_out[0]), int'(s9[8]));
            s9 = {s9[7:0], ~(s9[8] ^ s9[4])};
        end
        noise_sel = '0;
    endtask

    initial begin
        t_reset();
        t_fast();
        t_base();
        t_join_a();
        t_join_b();
        t_filter();
        t_noise();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule